// File: doc/BRIEF.md
# Exact Leading-One Normalizer

This block takes the two terms that a carry-propagate adder is about to sum and reports where the most significant one of the sum's magnitude lies. The sum is treated as a two's-complement value, and its magnitude is taken before the search. The position is exact. A correction shift by one is never needed, so the normalize step can act on the count as soon as it is available.

The block also contains the shifter that left-justifies the magnitude using that count. It outputs the weight of the leading one, which the next stage adds to the exponent. It reports whether the sum is negative and whether it is zero.

All logic is combinational. The outputs follow the present operands with no register in the path.

The block works on a field one bit wider than the operands, so the magnitude of any sum fits without overflow. The worst case is two most-negative operands, whose sum is -2^N.

Top module: `lza_exact`

## Requirements
- R1: `sign_o` is 1 exactly when the signed sum A+B of the two N-bit operands is negative.
- R2: `zero_o` is 1 exactly when A+B equals zero. In that case `shift_o`, `norm_o` and `exp_o` are all 0.
- R3: For a nonzero sum, `shift_o` equals the number of leading zeros of |A+B| held in an (N+1)-bit unsigned field, so its range is 0 to N.
- R4: A negative sum is measured by its magnitude. Two most-negative operands give |A+B| = 2^N, and therefore `shift_o` = 0 with `sign_o` = 1.
- R5: `norm_o` equals |A+B| shifted left by `shift_o` within N+1 bits. For a nonzero sum its bit N is 1.
- R6: For a nonzero sum, `exp_o` equals N minus `shift_o`, which is the bit index of the leading one of |A+B|.
- R7: All outputs are a function of the present `a_i` and `b_i` only. A new operand pair is fully reflected on every output within the same clock period, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First adder term, two's complement |
| b_i | input | N | Second adder term, two's complement |
| shift_o | output | $clog2(N+1) | Leading-zero count of the sum magnitude |
| zero_o | output | 1 | Sum is zero |
| sign_o | output | 1 | Sum is negative |
| norm_o | output | N+1 | Left-justified sum magnitude |
| exp_o | output | $clog2(N+1) | Bit index of the leading one (exponent adjustment) |

## Verification
The hardest case is when magnitude selection and leading-zero counting interact on the same operand pair. This happens when a negative sum's magnitude is a power of two: the two's-complement form of the sum has many leading ones but only one set bit in its magnitude.

Such cases are provoked with opposite-sign pairs whose sums are -1 and -2^k for many k. Pairs of all-ones operands and pairs of minimum values are also applied.

Each vector is judged against a bench-side model. The model forms the true sum, negates it arithmetically and counts zeros by a plain scan. The bench then compares all five outputs.

// File: rtl/lza_pkg.sv
package lza_pkg;
  // width of a count that must hold 0..n inclusive
  function automatic int unsigned lza_cnt_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/lza_dual_adder.sv
// Compound adder: forms A+B and -(A+B) side by side from the raw operands,
// then selects the non-negative one by the sum's sign.
module lza_dual_adder #(
  parameter int unsigned N = 64,
  localparam int unsigned W = N + 1
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o
);
  logic [W-1:0] a_ext;
  logic [W-1:0] b_ext;
  logic [W-1:0] pos_sum;
  logic [W-1:0] neg_sum;

  always_comb begin
    a_ext   = {a_i[N-1], a_i};
    b_ext   = {b_i[N-1], b_i};
    pos_sum = a_ext + b_ext;
    // -(A+B) = ~A + ~B + 2, evaluated concurrently with the direct sum
    neg_sum = (~a_ext) + (~b_ext) + W'(2);
    neg_o   = pos_sum[W-1];
    mag_o   = neg_o ? neg_sum : pos_sum;
  end

  always_comb begin
    AST_PAIR_CANCELS: assert (pos_sum + neg_sum == '0) // R4
      else $error("compound adder halves disagree");
  end
endmodule

// File: rtl/lza_lzc.sv
// Leading-zero counter over a W-bit vector; count forced to 0 on all-zero.
module lza_lzc #(
  parameter int unsigned W  = 65,
  parameter int unsigned CW = 7
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o,
  output logic          none_o
);
  logic found;

  always_comb begin
    found = 1'b0;
    cnt_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && vec_i[i]) begin
        found = 1'b1;
        cnt_o = CW'(W - 1 - i);
      end
    end
    none_o = !found;
  end

  always_comb begin
    AST_LEAD_BIT_SET: assert (none_o || vec_i[W - 1 - int'(cnt_o)]) // R3
      else $error("count does not land on a one");
    AST_NONE_MEANS_EMPTY: assert (!none_o || (vec_i == '0)) // R2
      else $error("empty flag with nonzero vector");
  end
endmodule

// File: rtl/lza_norm_shift.sv
// Logarithmic left shifter: one stage per count bit.
module lza_norm_shift #(
  parameter int unsigned W  = 65,
  parameter int unsigned CW = 7
) (
  input  logic [W-1:0]  data_i,
  input  logic [CW-1:0] amt_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] stage [CW+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    if (STEP < W) begin : g_shift
      assign stage[k+1] = amt_i[k] ? {stage[k][W-1-STEP:0], {STEP{1'b0}}} : stage[k];
    end else begin : g_clear
      assign stage[k+1] = amt_i[k] ? '0 : stage[k];
    end
  end

  assign data_o = stage[CW];
endmodule

// File: rtl/lza_exact.sv
module lza_exact #(
  parameter int unsigned N = 64,
  localparam int unsigned W  = N + 1,
  localparam int unsigned CW = lza_pkg::lza_cnt_w(N)
) (
  input  logic [N-1:0]  a_i,
  input  logic [N-1:0]  b_i,
  output logic [CW-1:0] shift_o,
  output logic          zero_o,
  output logic          sign_o,
  output logic [W-1:0]  norm_o,
  output logic [CW-1:0] exp_o
);
  logic [W-1:0]  mag;
  logic          neg;
  logic [CW-1:0] cnt;
  logic          none;

  lza_dual_adder #(.N(N)) u_add (
    .a_i   (a_i),
    .b_i   (b_i),
    .mag_o (mag),
    .neg_o (neg)
  );

  lza_lzc #(.W(W), .CW(CW)) u_lzc (
    .vec_i  (mag),
    .cnt_o  (cnt),
    .none_o (none)
  );

  lza_norm_shift #(.W(W), .CW(CW)) u_shf (
    .data_i (mag),
    .amt_i  (cnt),
    .data_o (norm_o)
  );

  always_comb begin
    shift_o = cnt;
    zero_o  = none;
    sign_o  = neg;
    exp_o   = none ? '0 : CW'(N) - cnt;
  end

  always_comb begin
    AST_ZERO_CLEARS: assert (!zero_o || (shift_o == '0 && norm_o == '0 && exp_o == '0)) // R2
      else $error("zero sum with nonzero outputs");
    AST_NORM_MSB: assert (zero_o || norm_o[W-1]) // R5
      else $error("normalized value not left-justified");
    AST_EXP_PLUS_SHIFT: assert (zero_o || (int'(exp_o) + int'(shift_o) == int'(N))) // R6
      else $error("exponent and shift inconsistent");
    AST_SIGN_NOT_ZERO: assert (!(sign_o && zero_o)) // R1
      else $error("negative and zero together");
  end
endmodule

// File: tb/lza_exact_tb.sv
module lza_exact_tb;
  localparam int unsigned N  = 64;
  localparam int unsigned W  = N + 1;
  localparam int unsigned CW = $clog2(N + 1);

  typedef struct {
    logic [N-1:0]  a;
    logic [N-1:0]  b;
    logic [CW-1:0] shift;
    logic          zero;
    logic          sign;
    logic [W-1:0]  norm;
    logic [CW-1:0] expo;
  } exp_t;

  logic clk;
  logic [N-1:0]  a_i, b_i;
  logic [CW-1:0] shift_o, exp_o;
  logic          zero_o, sign_o;
  logic [W-1:0]  norm_o;

  exp_t sb_q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   drv_done = 0;

  lza_exact #(.N(N)) u_dut (
    .a_i(a_i), .b_i(b_i), .shift_o(shift_o), .zero_o(zero_o),
    .sign_o(sign_o), .norm_o(norm_o), .exp_o(exp_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  // bench-side model: true sum, arithmetic negation, plain scan
  function automatic exp_t model(input logic [N-1:0] a, input logic [N-1:0] b);
    exp_t e;
    logic [W-1:0] s, m;
    int lz;
    e.a = a; e.b = b;
    s = W'($signed(a)) + W'($signed(b));
    e.sign = s[W-1];
    m = e.sign ? (W'(0) - s) : s;
    lz = 0;
    while (lz < int'(W) && m[W-1-lz] == 1'b0) lz++;
    e.zero = (m == '0);
    if (e.zero) begin
      e.shift = '0; e.norm = '0; e.expo = '0;
    end else begin
      e.shift = CW'(lz);
      e.norm  = m << lz;
      e.expo  = CW'(int'(N) - lz);
    end
    return e;
  endfunction

  task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b);
    @(posedge clk);
    #1;
    a_i = a;
    b_i = b;
    sb_q.push_back(model(a, b));
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: compares one result per falling edge (R7: same period)
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_vec++;
        chk(sign_o == e.sign,   "R1", "sign",  W'(sign_o),  W'(e.sign));
        chk(zero_o == e.zero,   "R2", "zero",  W'(zero_o),  W'(e.zero));
        chk(shift_o == e.shift, "R3", "shift", W'(shift_o), W'(e.shift));
        chk(norm_o == e.norm,   "R5", "norm",  norm_o,      e.norm);
        chk(exp_o == e.expo,    "R6", "exp",   W'(exp_o),   W'(e.expo));
      end else if (drv_done) begin
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
      end
    end
  end

  // watchdog
  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  localparam logic [N-1:0] ONES = '1;
  localparam logic [N-1:0] MINV = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] MAXV = {1'b0, {(N-1){1'b1}}};

  initial begin
    a_i = '0; b_i = '0;
    drive('0, '0);                  // R2 zero at start
    drive(ONES, ONES);              // -2: sign, shift N-1 (R1 R3)
    drive(MINV, MINV);              // R4 -2^N, shift 0
    drive(MAXV, MAXV);              // large positive
    drive(MAXV, MINV);              // -1, shift N (R3 R4)
    drive(ONES, 64'd1);             // R2 cancels to zero
    drive(64'd5, -64'sd5);          // R2 opposite values
    drive(64'd1, -64'sd2);          // -1
    drive(MINV, '0);                // -2^(N-1)
    for (int k = 0; k < int'(N); k++) begin
      logic [N-1:0] p;
      p = N'(1) << k;
      drive(p, '0);                 // single bit, positive (R3 R6)
      drive('0, -p);                // -2^k magnitude power of two (R4)
      drive(p, p);                  // doubled single bit
      drive(ONES, p);               // 2^k - 1, one position lower
    end
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      drive(ra, rb);
      drive(ra, -ra + N'($urandom_range(0, 8)) - N'(4)); // near cancellation
      drive(ra >> $urandom_range(0, N-1), rb >> $urandom_range(0, N-1));
    end
    @(posedge clk);
    drv_done = 1;
  end
endmodule